// File: doc/BRIEF.md
# Shared-Word Memory with Contention Arbiter

Two independent ports share one memory of 2^ADDR_W words, each DATA_W bits wide. Each port has an enable, a write strobe, an output enable, an address, write data and two lane enables that select the upper and lower halves of the word. When both ports are enabled and their addresses are equal, an arbiter names one winner. The other port gets an active-low busy flag, and any write from that port is dropped. The winner's access is not affected.

The arbiter decides by seniority. A port whose enable and address were both already present in the previous cycle beats a port that has just arrived. This one rule covers both cases: one enable asserted before the other at the same address, and one address settling on the location before the other. If both ports arrive in the same cycle, the left port wins. The decision is kept for as long as the addresses stay equal and both ports stay enabled. Busy is released in the same cycle that the match ends.

A mode input sets how the device is used. In master mode the device drives its own busy outputs. In slave mode the busy outputs stay inactive, and busy inputs from a master device gate this device's writes instead. Devices can then be placed side by side to build wider words under one arbiter.

Top module: `dpr_busy_top`

## Requirements
- R1: After reset both busy outputs are high (inactive) and both read-data outputs are zero.
- R2: If both ports are enabled at different addresses, or only one port is enabled, no busy output is low and every write lands.
- R3: In master mode, if one port has been enabled at an address since the previous cycle and the other port now enables at that address, the newcomer's busy goes low in that same cycle. The other busy stays high. Both busy outputs are never low together.
- R4: In master mode, if both ports are enabled and one port's address has been held since the previous cycle, then when the other port's address moves onto it, the mover's busy goes low in that same cycle.
- R5: If both ports enable at the same address in the same cycle, or both move onto a common address together, the left port wins and the right busy goes low.
- R6: While both ports stay enabled with equal addresses, the loser stays the same, even if both addresses move together.
- R7: Busy goes high in the same cycle that the addresses differ or either enable drops.
- R8: In master mode a write from the port whose busy is low is discarded, and the word keeps its old value. A write from the winning port lands.
- R9: In slave mode (master_i = 0) both busy outputs stay high. A write from a port whose busy input is low is discarded. A write from a port whose busy input is high lands.
- R10: Lane enable ub gates data bits [DATA_W-1:DATA_W/2] and lb gates bits [DATA_W/2-1:0]. A lane whose enable is low keeps its stored value.
- R11: A read (en = 1, we = 0) returns the stored word on rdata one clock edge later. Both ports reading the same address both get the word, whatever the busy state. rdata is zero while that port's oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1: drive busy outputs; 0: take busy from the inputs |
| l_en_i | input | 1 | Left port enable |
| l_we_i | input | 1 | Left write strobe (1 = write) |
| l_oe_i | input | 1 | Left output enable |
| l_ub_i | input | 1 | Left upper-lane enable |
| l_lb_i | input | 1 | Left lower-lane enable |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left read data |
| l_busy_no | output | 1 | Left busy, active low (master mode) |
| l_busy_ni | input | 1 | Left busy from a master device, active low (slave mode) |
| r_en_i | input | 1 | Right port enable |
| r_we_i | input | 1 | Right write strobe (1 = write) |
| r_oe_i | input | 1 | Right output enable |
| r_ub_i | input | 1 | Right upper-lane enable |
| r_lb_i | input | 1 | Right lower-lane enable |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right read data |
| r_busy_no | output | 1 | Right busy, active low (master mode) |
| r_busy_ni | input | 1 | Right busy from a master device, active low (slave mode) |

## Verification
Busy and the write gate are combinational from the current inputs and the registered ownership. They are due in the same cycle as the stimulus, so the bench changes inputs just after a falling edge and samples busy 1 ns later, before the next rising edge. Writes take effect at the following rising edge. Read data comes out of a register and is due one rising edge after the request, so the bench samples rdata 1 ns after that edge. Discarded writes are checked by reading the word back through a port after the conflict has ended.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NSIDE = 2;
  localparam int unsigned NLANE = 2;
  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} owner_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSIDE-1:0]              en_i,
  input  logic [NSIDE-1:0][ADDR_W-1:0]  addr_i,
  output logic [NSIDE-1:0]              lose_o
);
  logic [NSIDE-1:0]             en_q;
  logic [NSIDE-1:0][ADDR_W-1:0] addr_q;
  logic [NSIDE-1:0]             settled;
  owner_e owner_q, owner_d, fresh;
  logic match;

  always_comb begin
    match = en_i[0] & en_i[1] & (addr_i[0] == addr_i[1]);
    for (int s = 0; s < NSIDE; s++)
      settled[s] = en_q[s] & (addr_q[s] == addr_i[s]);
    // seniority wins; equal seniority goes left
    fresh   = (settled[1] && !settled[0]) ? OWN_RIGHT : OWN_LEFT;
    owner_d = !match ? OWN_NONE : ((owner_q == OWN_NONE) ? fresh : owner_q);
    lose_o[0] = match & (owner_d == OWN_RIGHT);
    lose_o[1] = match & (owner_d == OWN_LEFT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NONE;
      en_q    <= '0;
      addr_q  <= '0;
    end else begin
      owner_q <= owner_d;
      en_q    <= en_i;
      addr_q  <= addr_i;
    end
  end
endmodule

// File: rtl/dpr_port_ctl.sv
module dpr_port_ctl
  import dpr_pkg::*;
(
  input  logic             master_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic             ub_i,
  input  logic             lb_i,
  input  logic             lose_i,
  input  logic             busy_ni,
  output logic [NLANE-1:0] wr_lane_o,
  output logic             busy_no
);
  logic blocked;
  assign blocked   = master_i ? lose_i : ~busy_ni;
  assign wr_lane_o = {ub_i, lb_i} & {NLANE{en_i & we_i & ~blocked}};
  assign busy_no   = ~(master_i & lose_i);
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 18
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NSIDE-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NSIDE-1:0][NLANE-1:0]   wr_lane_i,
  input  logic [NSIDE-1:0][DATA_W-1:0]  wdata_i,
  input  logic [NSIDE-1:0]              rd_en_i,
  output logic [NSIDE-1:0][DATA_W-1:0]  rdata_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = DATA_W / NLANE;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first so left lands last if slave mode lets both through
  always_ff @(posedge clk_i) begin
    for (int s = NSIDE - 1; s >= 0; s--)
      for (int k = 0; k < NLANE; k++)
        if (wr_lane_i[s][k])
          mem[addr_i[s]][k*LANE_W +: LANE_W] <= wdata_i[s][k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else
      for (int s = 0; s < NSIDE; s++)
        if (rd_en_i[s]) rdata_o[s] <= mem[addr_i[s]];
  end
endmodule

// File: rtl/dpr_busy_top.sv
module dpr_busy_top
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic              l_ub_i,
  input  logic              l_lb_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_busy_no,
  input  logic              l_busy_ni,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic              r_ub_i,
  input  logic              r_lb_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_busy_no,
  input  logic              r_busy_ni
);
  logic [NSIDE-1:0]             en, we, ub, lb, oe, bsy_in, bsy_out, lose, rd_en;
  logic [NSIDE-1:0][ADDR_W-1:0] addr;
  logic [NSIDE-1:0][DATA_W-1:0] wdata, rdata;
  logic [NSIDE-1:0][NLANE-1:0]  wr_lane;

  assign en     = {r_en_i, l_en_i};
  assign we     = {r_we_i, l_we_i};
  assign ub     = {r_ub_i, l_ub_i};
  assign lb     = {r_lb_i, l_lb_i};
  assign oe     = {r_oe_i, l_oe_i};
  assign bsy_in = {r_busy_ni, l_busy_ni};
  assign addr   = {r_addr_i, l_addr_i};
  assign wdata  = {r_wdata_i, l_wdata_i};

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i, .rst_ni, .en_i(en), .addr_i(addr), .lose_o(lose)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dpr_port_ctl u_ctl (
      .master_i, .en_i(en[s]), .we_i(we[s]), .ub_i(ub[s]), .lb_i(lb[s]),
      .lose_i(lose[s]), .busy_ni(bsy_in[s]),
      .wr_lane_o(wr_lane[s]), .busy_no(bsy_out[s])
    );
    assign rd_en[s] = en[s] & ~we[s];
  end

  dpr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni, .addr_i(addr), .wr_lane_i(wr_lane), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata)
  );

  assign l_rdata_o = oe[0] ? rdata[0] : '0;
  assign r_rdata_o = oe[1] ? rdata[1] : '0;
  assign l_busy_no = bsy_out[0];
  assign r_busy_no = bsy_out[1];
endmodule

// File: rtl/dpr_busy_chk.sv
module dpr_busy_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_en_i,
  input logic              r_en_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              l_busy_no,
  input logic              r_busy_no,
  input logic              l_busy_ni,
  input logic              r_busy_ni,
  input logic              l_wr,
  input logic              r_wr
);
  logic hit;
  assign hit = l_en_i && r_en_i && (l_addr_i == r_addr_i);

  p_one_loser_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_busy_no || r_busy_no);

  p_free_when_apart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (l_busy_no && r_busy_no));

  p_loser_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && master_i && $past(master_i) && hit && $past(hit))
      |-> (l_busy_no == $past(l_busy_no)) && (r_busy_no == $past(r_busy_no)));

  p_left_loser_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !l_busy_no) |-> !l_wr);

  p_right_loser_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !r_busy_no) |-> !r_wr);

  p_slave_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no));

  p_slave_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> ((l_busy_ni || !l_wr) && (r_busy_ni || !r_wr)));
endmodule

bind dpr_busy_top dpr_busy_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i),
  .l_en_i(l_en_i), .r_en_i(r_en_i), .l_addr_i(l_addr_i), .r_addr_i(r_addr_i),
  .l_busy_no(l_busy_no), .r_busy_no(r_busy_no),
  .l_busy_ni(l_busy_ni), .r_busy_ni(r_busy_ni),
  .l_wr(|wr_lane[0]), .r_wr(|wr_lane[1])
);

// File: tb/tb_dpr_busy_top.sv
module tb_dpr_busy_top;
  localparam int AW = 12;
  localparam int DW = 18;

  logic clk = 0, rst_ni = 0, master = 1;
  logic l_en = 0, l_we = 0, l_oe = 1, l_ub = 1, l_lb = 1, l_bi = 1;
  logic r_en = 0, r_we = 0, r_oe = 1, r_ub = 1, r_lb = 1, r_bi = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic [DW-1:0] l_rd, r_rd;
  logic l_bo, r_bo;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dpr_busy_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master),
    .l_en_i(l_en), .l_we_i(l_we), .l_oe_i(l_oe), .l_ub_i(l_ub), .l_lb_i(l_lb),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .l_busy_no(l_bo), .l_busy_ni(l_bi),
    .r_en_i(r_en), .r_we_i(r_we), .r_oe_i(r_oe), .r_ub_i(r_ub), .r_lb_i(r_lb),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd),
    .r_busy_no(r_bo), .r_busy_ni(r_bi)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drv_l(input bit en, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = en; l_we = we; l_addr = a; l_wd = d;
  endtask
  task automatic drv_r(input bit en, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = en; r_we = we; r_addr = a; r_wd = d;
  endtask
  task automatic idle();
    @(negedge clk); drv_l(0, 0, '0, '0); drv_r(0, 0, '0, '0);
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); drv_l(1, 1, a, d); drv_r(0, 0, '0, '0);
    idle();
  endtask
  task automatic rd_l(input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk); drv_l(1, 0, a, '0); drv_r(0, 0, '0, '0);
    @(posedge clk); #1 q = l_rd;
  endtask
  task automatic rd_r(input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk); drv_r(1, 0, a, '0); drv_l(0, 0, '0, '0);
    @(posedge clk); #1 q = r_rd;
  endtask

  task automatic t_reset();
    #1;
    chk(l_bo && r_bo, "R1 busy after reset", {l_bo, r_bo}, 2'b11);
    chk(l_rd == 0 && r_rd == 0, "R1 rdata after reset", {l_rd[15:0], r_rd[15:0]}, 0);
  endtask

  task automatic t_no_conflict();
    logic [DW-1:0] q;
    @(negedge clk); drv_l(1, 1, 12'h010, 18'h1_2345); drv_r(1, 1, 12'h011, 18'h2_ABCD);
    #1 chk(l_bo && r_bo, "R2 different addresses", {l_bo, r_bo}, 2'b11);
    idle();
    rd_l(12'h011, q); chk(q == 18'h2_ABCD, "R2 right write landed", q, 18'h2_ABCD);
    rd_r(12'h010, q); chk(q == 18'h1_2345, "R2 left write landed", q, 18'h1_2345);
  endtask

  task automatic t_enable_first();
    idle();
    @(negedge clk); drv_l(1, 0, 12'h020, '0);
    @(negedge clk); drv_r(1, 0, 12'h020, '0);
    #1 chk(!r_bo && l_bo, "R3 left enabled first, right busy", {l_bo, r_bo}, 2'b10);
    idle();
    #1 chk(l_bo && r_bo, "R7 release on enable drop", {l_bo, r_bo}, 2'b11);
    @(negedge clk); drv_r(1, 0, 12'h021, '0);
    @(negedge clk); drv_l(1, 0, 12'h021, '0);
    #1 chk(!l_bo && r_bo, "R3 right enabled first, left busy", {l_bo, r_bo}, 2'b01);
    @(negedge clk); drv_r(0, 0, 12'h021, '0);
    #1 chk(l_bo && r_bo, "R7 release when winner disables", {l_bo, r_bo}, 2'b11);
  endtask

  task automatic t_address_first_hold();
    idle();
    @(negedge clk); drv_l(1, 0, 12'h030, '0); drv_r(1, 0, 12'h031, '0);
    @(negedge clk); drv_l(1, 0, 12'h031, '0);
    #1 chk(!l_bo && r_bo, "R4 right address first, left busy", {l_bo, r_bo}, 2'b01);
    @(negedge clk);
    #1 chk(!l_bo && r_bo, "R6 loser held", {l_bo, r_bo}, 2'b01);
    @(negedge clk); drv_l(1, 0, 12'h040, '0); drv_r(1, 0, 12'h040, '0);
    #1 chk(!l_bo && r_bo, "R6 loser held across joint move", {l_bo, r_bo}, 2'b01);
    @(negedge clk); drv_l(1, 0, 12'h041, '0);
    #1 chk(l_bo && r_bo, "R7 release on address mismatch", {l_bo, r_bo}, 2'b11);
    @(negedge clk); drv_r(1, 0, 12'h041, '0);
    #1 chk(!r_bo && l_bo, "R4 left address first, right busy", {l_bo, r_bo}, 2'b10);
  endtask

  task automatic t_tie();
    idle();
    @(negedge clk); drv_l(1, 0, 12'h050, '0); drv_r(1, 0, 12'h050, '0);
    #1 chk(!r_bo && l_bo, "R5 same-cycle tie goes left", {l_bo, r_bo}, 2'b10);
    @(negedge clk); drv_l(1, 0, 12'h051, '0); drv_r(1, 0, 12'h052, '0);
    @(negedge clk); drv_l(1, 0, 12'h053, '0); drv_r(1, 0, 12'h053, '0);
    #1 chk(!r_bo && l_bo, "R5 joint move tie goes left", {l_bo, r_bo}, 2'b10);
  endtask

  task automatic t_blocked_write();
    logic [DW-1:0] q;
    idle();
    wr_l(12'h060, 18'h0_1111);
    @(negedge clk); drv_l(1, 0, 12'h060, '0);
    @(negedge clk); drv_r(1, 1, 12'h060, 18'h3_DEAD);
    #1 chk(!r_bo, "R8 writing loser busy", r_bo, 0);
    idle();
    rd_r(12'h060, q); chk(q == 18'h0_1111, "R8 loser write discarded", q, 18'h0_1111);
    idle();
    @(negedge clk); drv_r(1, 0, 12'h061, '0);
    @(negedge clk); drv_r(1, 1, 12'h061, 18'h2_BEEF); drv_l(1, 0, 12'h061, '0);
    #1 chk(!l_bo && r_bo, "R8 winner writes while left busy", {l_bo, r_bo}, 2'b01);
    idle();
    rd_l(12'h061, q); chk(q == 18'h2_BEEF, "R8 winner write landed", q, 18'h2_BEEF);
  endtask

  task automatic t_slave();
    logic [DW-1:0] q;
    idle();
    wr_l(12'h070, 18'h0_0F0F);
    master = 0;
    @(negedge clk); l_bi = 0; drv_l(1, 1, 12'h070, 18'h1_5555); drv_r(1, 0, 12'h070, '0);
    #1 chk(l_bo && r_bo, "R9 slave busy outputs high", {l_bo, r_bo}, 2'b11);
    idle();
    rd_r(12'h070, q); chk(q == 18'h0_0F0F, "R9 busy input blocks write", q, 18'h0_0F0F);
    l_bi = 1;
    wr_l(12'h070, 18'h1_5555);
    rd_r(12'h070, q); chk(q == 18'h1_5555, "R9 write passes with busy input high", q, 18'h1_5555);
    master = 1;
  endtask

  task automatic t_lanes();
    logic [DW-1:0] q;
    idle();
    wr_l(12'h080, 18'h0_0000);
    l_lb = 0; wr_l(12'h080, 18'h3_FFFF); l_lb = 1;
    rd_r(12'h080, q); chk(q == 18'h3_FE00, "R10 upper lane only", q, 18'h3_FE00);
    l_ub = 0; wr_l(12'h080, 18'h0_0123); l_ub = 1;
    rd_r(12'h080, q); chk(q == 18'h3_FF23, "R10 lower lane only", q, 18'h3_FF23);
  endtask

  task automatic t_dual_read();
    idle();
    wr_l(12'h090, 18'h2_4681);
    @(negedge clk); drv_l(1, 0, 12'h090, '0); drv_r(1, 0, 12'h090, '0);
    @(posedge clk); #1;
    chk(l_rd == 18'h2_4681, "R11 left reads shared word", l_rd, 18'h2_4681);
    chk(r_rd == 18'h2_4681, "R11 busy right still reads", r_rd, 18'h2_4681);
    l_oe = 0; #1;
    chk(l_rd == 0, "R11 oe low gives zero", l_rd, 0);
    l_oe = 1;
  endtask

  initial begin
    #(4 * 100000);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    t_no_conflict();
    t_enable_first();
    t_address_first_hold();
    t_tie();
    t_blocked_write();
    t_slave();
    t_lanes();
    t_dual_read();
    idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule